// File: doc/BRIEF.md
# Complex Accumulator Register Bank

This block is the host-visible register file of a DSP coprocessor. It decodes a 32-bit host bus that carries word (16-bit) and double-word (32-bit) accesses. It holds the data-side control registers and a page of host-interface registers. Its central register is a complex accumulator with two 34-bit halves, one real and one imaginary.

The host never sees the whole accumulator. A single double-word access reaches a 16-bit window (bits 30..15) of each half. Every load rewrites the bits around the loaded value by fixed rules:
- the rounding-control bit is inserted below the window;
- bit 30 is copied into the three guard bits;
- the fraction bits are cleared, except on the extended load.

A command-list engine has its own load port into the accumulator. It offers a plain load and an extended load.

The block also enforces the direction of each register:
- read-only status registers reflect inputs and ignore writes;
- the write-only abort register produces a one-cycle pulse.

Misaligned accesses are dropped, and they raise a sticky error flag.

Top module: `dsp_regbank`

## Requirements
- R1: A double-word host write to offset 0x014 loads real bits 30..15 from bus bits 15..0 and imaginary bits 30..15 from bus bits 31..16. A double-word read of 0x014 returns the same window in the same positions.
- R2: On a host write to the accumulator, bit 14 of each written half takes bit 0 of the parameter register (offset 0x000) as it stood before that cycle.
- R3: After any accumulator load, bits 33..31 of each half equal bit 30 of that half.
- R4: A host write clears bits 13..0 of the written half. A plain command-list load (`cl_load`=1, `cl_ext`=0) does the same, and it takes bits 30..14 of the half from `cl_re`/`cl_im` bits 30..14.
- R5: An extended command-list load (`cl_ext`=1) copies `cl_re`/`cl_im` bits 30..0 unchanged into bits 30..0 of each half.
- R6: For a half that a host write and a command-list load both target in the same cycle, the host write wins.
- R7: These registers are read/write and read back what was written:
  - data side: parameter 0x000, X 0x008, Y 0x00C, Z 0x010, repeat 0x018, list pointer 0x020, error address 0x024;
  - host-interface page: mask 0x100C, extension 0x1010.

  A word access (`bus_dw`=0) uses bus bits 15..0. Address bit 1 selects the upper (1) or lower (0) half of the 32-bit register.
- R8: The read-only registers return their status inputs and ignore writes: overflow 0x004, list status 0x1000, interrupt 0x1008 and NMI status 0x100C+8 = 0x1014.
- R9: A write to the abort register (0x1004) drives `abort_pulse` high for exactly the next cycle. A read of 0x1004 returns zero.
- R10: An access is misaligned when it is a double-word access with address bits 1..0 not 00, or a word access with address bit 0 set. A misaligned write changes nothing, and a misaligned read returns zero. Either one sets `misalign_err` from the next cycle until reset.
- R11: After reset, the accumulator, all read/write registers, `misalign_err` and `abort_pulse` are zero.
- R12: Reads of unmapped offsets (for example 0x01C, 0x1018) return zero. Writes to them change no register.
- R13: A word host write to 0x014 loads only the addressed half (address bit 1: 0 = real, 1 = imaginary) from bus bits 15..0, with R2 to R4 applied. The other half is kept, or is taken from a concurrent command-list load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (13) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_dw | input | 1 | 1 = double-word access, 0 = word access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| cl_load | input | 1 | Command-list accumulator load |
| cl_ext | input | 1 | 1 = extended load, 0 = plain load |
| cl_re | input | 31 | Real load value, bits 30..0 |
| cl_im | input | 31 | Imaginary load value, bits 30..0 |
| ovf_in | input | 32 | Overflow status |
| clstat_in | input | 32 | Command-list status |
| dspint_in | input | 32 | Interrupt status |
| nmistat_in | input | 32 | NMI status |
| acc_re | output | 34 | Real half of the accumulator |
| acc_im | output | 34 | Imaginary half of the accumulator |
| abort_pulse | output | 1 | One-cycle pulse after an abort write |
| misalign_err | output | 1 | Sticky misaligned-access flag |

## Verification
The accumulator is loaded from three sources: double-word host writes, word host writes to either half, and plain and extended list loads. Window values with bit 30 both set and clear separate correct sign extension from zero fill. List values with nonzero low bits separate the plain load, which clears them, from the extended load, which keeps them. Toggling the rounding bit between host writes shows that bit 14 follows the parameter register and not the data. Simultaneous host and list loads, word writes to each register half, and writes to read-only, write-only, unmapped and misaligned offsets are each checked at the read port and at the accumulator outputs.

// File: rtl/dsp_regbank.sv
module dsp_regbank #(
  parameter int AW      = 13,
  parameter int RND_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_dw,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          cl_load,
  input  logic          cl_ext,
  input  logic [30:0]   cl_re,
  input  logic [30:0]   cl_im,
  input  logic [31:0]   ovf_in,
  input  logic [31:0]   clstat_in,
  input  logic [31:0]   dspint_in,
  input  logic [31:0]   nmistat_in,
  output logic [33:0]   acc_re,
  output logic [33:0]   acc_im,
  output logic          abort_pulse,
  output logic          misalign_err
);

  localparam logic [AW-1:0] A_PARAM = AW'('h000);
  localparam logic [AW-1:0] A_OVF   = AW'('h004);
  localparam logic [AW-1:0] A_X     = AW'('h008);
  localparam logic [AW-1:0] A_Y     = AW'('h00C);
  localparam logic [AW-1:0] A_Z     = AW'('h010);
  localparam logic [AW-1:0] A_ACC   = AW'('h014);
  localparam logic [AW-1:0] A_REP   = AW'('h018);
  localparam logic [AW-1:0] A_CLPTR = AW'('h020);
  localparam logic [AW-1:0] A_EADR  = AW'('h024);
  localparam logic [AW-1:0] A_CLST  = AW'('h1000);
  localparam logic [AW-1:0] A_ABORT = AW'('h1004);
  localparam logic [AW-1:0] A_INT   = AW'('h1008);
  localparam logic [AW-1:0] A_MASK  = AW'('h100C);
  localparam logic [AW-1:0] A_EXTN  = AW'('h1010);
  localparam logic [AW-1:0] A_NMI   = AW'('h1014);

  logic [31:0] param_q, x_q, y_q, z_q, rep_q, clptr_q, eadr_q, mask_q, extn_q;
  logic [31:0] rv;

  wire          misal  = (bus_wr | bus_rd) & (bus_dw ? (bus_addr[1:0] != 2'b00) : bus_addr[0]);
  wire          wr     = bus_wr & ~misal;
  wire          rd     = bus_rd & ~misal;
  wire          hi     = bus_addr[1];
  wire [AW-1:0] word_a = {bus_addr[AW-1:2], 2'b00};
  wire          wacc   = wr & (word_a == A_ACC);
  wire          wre    = wacc & (bus_dw | ~hi);
  wire          wim    = wacc & (bus_dw | hi);
  wire          rnd    = param_q[RND_BIT];
  wire [15:0]   im_win = bus_dw ? bus_wdata[31:16] : bus_wdata[15:0];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic dw, input logic h);
    if (dw)     return d;
    else if (h) return {d[15:0], old[15:0]};
    else        return {old[31:16], d[15:0]};
  endfunction

  function automatic logic [33:0] ld_host(input logic [15:0] w, input logic r);
    return {{3{w[15]}}, w, r, 14'b0};
  endfunction

  function automatic logic [33:0] ld_list(input logic [30:0] d, input logic ext);
    if (ext) return {{3{d[30]}}, d};
    else     return {{3{d[30]}}, d[30:14], 14'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
    end else begin
      if (wre)          acc_re <= ld_host(bus_wdata[15:0], rnd);
      else if (cl_load) acc_re <= ld_list(cl_re, cl_ext);
      if (wim)          acc_im <= ld_host(im_win, rnd);
      else if (cl_load) acc_im <= ld_list(cl_im, cl_ext);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      param_q <= '0; x_q <= '0; y_q <= '0; z_q <= '0; rep_q <= '0;
      clptr_q <= '0; eadr_q <= '0; mask_q <= '0; extn_q <= '0;
    end else if (wr) begin
      case (word_a)
        A_PARAM: param_q <= merge(param_q, bus_wdata, bus_dw, hi);
        A_X:     x_q     <= merge(x_q,     bus_wdata, bus_dw, hi);
        A_Y:     y_q     <= merge(y_q,     bus_wdata, bus_dw, hi);
        A_Z:     z_q     <= merge(z_q,     bus_wdata, bus_dw, hi);
        A_REP:   rep_q   <= merge(rep_q,   bus_wdata, bus_dw, hi);
        A_CLPTR: clptr_q <= merge(clptr_q, bus_wdata, bus_dw, hi);
        A_EADR:  eadr_q  <= merge(eadr_q,  bus_wdata, bus_dw, hi);
        A_MASK:  mask_q  <= merge(mask_q,  bus_wdata, bus_dw, hi);
        A_EXTN:  extn_q  <= merge(extn_q,  bus_wdata, bus_dw, hi);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_pulse  <= 1'b0;
      misalign_err <= 1'b0;
    end else begin
      abort_pulse  <= wr & (word_a == A_ABORT);
      misalign_err <= misalign_err | misal;
    end
  end

  always_comb begin
    case (word_a)
      A_PARAM: rv = param_q;
      A_OVF:   rv = ovf_in;
      A_X:     rv = x_q;
      A_Y:     rv = y_q;
      A_Z:     rv = z_q;
      A_ACC:   rv = {acc_im[30:15], acc_re[30:15]};
      A_REP:   rv = rep_q;
      A_CLPTR: rv = clptr_q;
      A_EADR:  rv = eadr_q;
      A_CLST:  rv = clstat_in;
      A_INT:   rv = dspint_in;
      A_MASK:  rv = mask_q;
      A_EXTN:  rv = extn_q;
      A_NMI:   rv = nmistat_in;
      default: rv = '0;
    endcase
  end

  assign bus_rdata = !rd ? 32'h0 : bus_dw ? rv : {16'h0, hi ? rv[31:16] : rv[15:0]};

  AST_ACC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wre && bus_dw) |=> (acc_re[30:15] == $past(bus_wdata[15:0]) && acc_im[30:15] == $past(bus_wdata[31:16]))); // R1
  AST_RND_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    wre |=> acc_re[14] == $past(param_q[RND_BIT])); // R2
  AST_GUARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re[33:31] == {3{acc_re[30]}}) && (acc_im[33:31] == {3{acc_im[30]}})); // R3
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wre || (cl_load && !cl_ext)) |=> acc_re[13:0] == 14'h0); // R4
  AST_EXT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_load && cl_ext && !wacc) |=> (acc_re[30:0] == $past(cl_re) && acc_im[30:0] == $past(cl_im))); // R5
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wre && cl_load) |=> acc_re[30:15] == $past(bus_wdata[15:0])); // R6
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !misal && word_a == A_ABORT) |=> abort_pulse); // R9
  AST_MISAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (misal || misalign_err) |=> misalign_err); // R10
  AST_MISAL_RDZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && misal) |-> bus_rdata == 32'h0); // R10
  AST_MISAL_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && misal && !cl_load) |=> ($stable(acc_re) && $stable(acc_im))); // R10

endmodule

// File: tb/dsp_regbank_test.sv
module dsp_regbank_test;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0, bus_dw = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cl_load = 0, cl_ext = 0;
  logic [30:0] cl_re = '0, cl_im = '0;
  logic [31:0] ovf_in = 32'hA5A5_0001, clstat_in = 32'h1234_5678;
  logic [31:0] dspint_in = 32'h0F0F_00F0, nmistat_in = 32'hCAFE_0003;
  logic [33:0] acc_re, acc_im;
  logic        abort_pulse, misalign_err;

  int errors = 0, checks = 0;
  logic [33:0] m_re = '0, m_im = '0;
  logic [31:0] m_rw [9];
  localparam logic [12:0] RW_A [9] = '{13'h000, 13'h008, 13'h00C, 13'h010, 13'h018,
                                       13'h020, 13'h024, 13'h100C, 13'h1010};

  dsp_regbank uut (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  function automatic logic [33:0] f_host(input logic [15:0] w, input logic r);
    return {{3{w[15]}}, w, r, 14'b0};
  endfunction
  function automatic logic [33:0] f_plain(input logic [30:0] d);
    return {{3{d[30]}}, d[30:14], 14'b0};
  endfunction
  function automatic logic [33:0] f_ext(input logic [30:0] d);
    return {{3{d[30]}}, d};
  endfunction
  function automatic logic [31:0] f_merge(input logic [31:0] o, input logic [31:0] d,
                                          input logic dw, input logic h);
    return dw ? d : h ? {d[15:0], o[15:0]} : {o[31:16], d[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d, input logic dw);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_dw = dw; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [12:0] a, input logic dw, input logic [31:0] exp,
                          input string tag);
    @(negedge clk);
    bus_addr = a; bus_dw = dw; bus_rd = 1;
    #1 chk(tag, {32'h0, bus_rdata}, {32'h0, exp});
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic list_load(input logic ext, input logic [30:0] re, input logic [30:0] im);
    @(negedge clk);
    cl_load = 1; cl_ext = ext; cl_re = re; cl_im = im;
    @(negedge clk);
    cl_load = 0;
    m_re = ext ? f_ext(re) : f_plain(re);
    m_im = ext ? f_ext(im) : f_plain(im);
  endtask

  task automatic host_acc(input logic [31:0] d, input logic dw, input logic h);
    logic r;
    r = m_rw[0][0];
    bus_write(13'h014 | {11'h0, h, 1'b0}, d, dw);
    if (dw || !h) m_re = f_host(d[15:0], r);
    if (dw || h)  m_im = f_host(dw ? d[31:16] : d[15:0], r);
  endtask

  task automatic chk_acc(input string tag);
    chk(tag, {30'h0, acc_re}, {30'h0, m_re});
    chk(tag, {30'h0, acc_im}, {30'h0, m_im});
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 9; i++) m_rw[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk_acc("R11 reset acc");
    chk("R11 reset err", {63'h0, misalign_err}, 64'h0);
    chk("R11 reset abort", {63'h0, abort_pulse}, 64'h0);
    bus_read(13'h000, 1, 32'h0, "R11 reset param");

    bus_write(13'h000, 32'h1, 1); m_rw[0] = 32'h1;
    host_acc(32'h8001_7FFF, 1, 0);
    chk_acc("R1 R2 R3 host dword load");
    bus_read(13'h014, 1, 32'h8001_7FFF, "R1 window read");
    bus_write(13'h000, 32'h0, 1); m_rw[0] = 32'h0;
    host_acc(32'h4000_C000, 1, 0);
    chk_acc("R2 rnd clear R3 sign");

    list_load(0, 31'h5555_3FFF, 31'h2AAA_1234);
    chk_acc("R4 plain load clears low");
    list_load(1, 31'h4000_3FFF, 31'h0000_1234);
    chk_acc("R5 ext load keeps low");

    @(negedge clk);
    bus_addr = 13'h014; bus_wdata = 32'h1111_2222; bus_dw = 1; bus_wr = 1;
    cl_load = 1; cl_ext = 1; cl_re = 31'h7FFF_FFFF; cl_im = 31'h7FFF_FFFF;
    @(negedge clk);
    bus_wr = 0; cl_load = 0;
    m_re = f_host(16'h2222, 1'b0); m_im = f_host(16'h1111, 1'b0);
    chk_acc("R6 host beats list");

    @(negedge clk);
    bus_addr = 13'h016; bus_wdata = 32'h0000_9ABC; bus_dw = 0; bus_wr = 1;
    cl_load = 1; cl_ext = 1; cl_re = 31'h0123_4567; cl_im = 31'h7FFF_FFFF;
    @(negedge clk);
    bus_wr = 0; cl_load = 0;
    m_re = f_ext(31'h0123_4567); m_im = f_host(16'h9ABC, 1'b0);
    chk_acc("R13 R6 word write imag with list load");
    host_acc(32'h0000_0F0F, 0, 0);
    chk_acc("R13 word write real only");

    bus_write(13'h008, 32'hDEAD_BEEF, 1); m_rw[1] = 32'hDEAD_BEEF;
    bus_write(13'h00A, 32'hFFFF_1234, 0); m_rw[1] = 32'h1234_BEEF;
    bus_read(13'h008, 1, 32'h1234_BEEF, "R7 word write upper half");
    bus_read(13'h008, 0, 32'h0000_BEEF, "R7 word read lower half");
    bus_write(13'h1010, 32'h0BAD_F00D, 1); m_rw[8] = 32'h0BAD_F00D;
    bus_read(13'h1010, 1, 32'h0BAD_F00D, "R7 extension reg");

    bus_write(13'h004, 32'hFFFF_FFFF, 1);
    bus_read(13'h004, 1, ovf_in, "R8 overflow ignores write");
    bus_read(13'h1000, 1, clstat_in, "R8 list status");
    bus_read(13'h1008, 1, dspint_in, "R8 interrupt status");
    bus_read(13'h1014, 1, nmistat_in, "R8 nmi status");

    @(negedge clk);
    bus_addr = 13'h1004; bus_wdata = 32'h1; bus_dw = 1; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    chk("R9 abort pulse high", {63'h0, abort_pulse}, 64'h1);
    @(negedge clk);
    chk("R9 abort pulse single", {63'h0, abort_pulse}, 64'h0);
    bus_read(13'h1004, 1, 32'h0, "R9 abort reads zero");

    bus_write(13'h01C, 32'hFFFF_FFFF, 1);
    bus_read(13'h01C, 1, 32'h0, "R12 unmapped 0x01C");
    bus_read(13'h1018, 1, 32'h0, "R12 unmapped 0x1018");
    chk_acc("R12 unmapped write no effect");

    chk("R10 err before", {63'h0, misalign_err}, 64'h0);
    bus_write(13'h00A, 32'h5555_5555, 1);
    chk("R10 err set", {63'h0, misalign_err}, 64'h1);
    bus_read(13'h008, 1, 32'h1234_BEEF, "R10 misaligned write ignored");
    bus_read(13'h009, 0, 32'h0, "R10 misaligned word read zero");
    bus_write(13'h015, 32'hFFFF_FFFF, 0);
    chk_acc("R10 misaligned acc write ignored");
    chk("R10 err sticky", {63'h0, misalign_err}, 64'h1);

    for (int it = 0; it < 400; it++) begin
      int op, k;
      logic dw, h;
      logic [31:0] d;
      op = $urandom % 4; k = $urandom % 9; dw = 1'($urandom); h = 1'($urandom);
      d = $urandom;
      case (op)
        0: begin
          bus_write(RW_A[k] | {11'h0, h & ~dw, 1'b0}, d, dw);
          m_rw[k] = f_merge(m_rw[k], d, dw, h & ~dw);
          bus_read(RW_A[k], 1, m_rw[k], "R7 random rw");
        end
        1: begin
          host_acc(d, dw, h & ~dw);
          chk_acc("R2 R3 R4 random host load");
          bus_read(13'h014, 1, {m_im[30:15], m_re[30:15]}, "R1 random window");
        end
        2: begin
          list_load(dw, 31'($urandom), 31'($urandom));
          chk_acc("R4 R5 random list load");
        end
        default: bus_read(RW_A[k] | {11'h0, h, 1'b0}, 0,
                          {16'h0, h ? m_rw[k][31:16] : m_rw[k][15:0]}, "R7 random word read");
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule